// File: doc/BRIEF.md
# Multi-Class Physical Register Free List

This block keeps the unallocated physical register numbers for the rename stage of an out-of-order core. One physical numbering is shared by four register classes: integer, floating point, condition code and vector. Each class has its own contiguous range and its own first-in first-out pool. The rename logic takes a fresh number from a class pool when it renames a destination register. Retirement or squash logic gives numbers back, either through a per-class release port or through one unified release port. The unified port works out the class from the number itself.

Each pool is a circular buffer as deep as its class range. After reset, each pool holds every number of its range except the lowest few, which are taken by the initial architectural mappings. Each class reports its free count and a non-empty flag. Two sticky error flags record an allocation from an empty class and a release into a full class.

Top module: `phys_free_list`

## Requirements
- R1: After reset, class c holds its range's numbers from BASE_c+RSV_c up to BASE_c+SIZE_c-1, in ascending order, and these come out first. The defaults are integer 0..7, floating point 8..15, condition code 16..19 and vector 20..27. Two numbers are reserved in each class, except condition code, which reserves one. This gives reset counts of 6, 6, 3 and 6.
- R2: Within a class, numbers are handed out in the order they entered the pool. A released number comes out after every number already queued.
- R3: The unified release port sends a number below 8 to integer and a number from 8 to 15 to floating point. A number from 16 to 19 goes to condition code. Any other number goes to vector, including numbers past the last vector index.
- R4: `free_cnt` field c, at bits [c*4 +: 4], gives the number of queued entries in class c, with classes ordered integer=0, fp=1, cc=2, vector=3. `nonempty[c]` is 1 exactly when that count is nonzero. The count never exceeds the class size.
- R5: An allocate request to an empty class sets the sticky `alloc_err` and leaves that class's count and contents unchanged.
- R6: An allocate and a single release to the same class in one cycle leave its count unchanged, even when the class is full.
- R7: A release into a full class, with no allocate in that cycle, is dropped. It sets the sticky `ovf_err` and leaves the count unchanged.
- R8: A direct release and a unified release to the same class in one cycle are both accepted when there is room. The direct one is queued ahead of the unified one.
- R9: Activity on one class does not change the count or the order of any other class.
- R10: `alloc_idx` field c, at bits [c*5 +: 5], shows the head of class c combinationally. The head advances at the clock edge where an allocate to a non-empty class is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 4 | Allocate request per class |
| alloc_idx | output | 20 | Head number per class, 5 bits each |
| rel_vld | input | 4 | Direct release valid per class |
| rel_idx | input | 20 | Direct release number per class, 5 bits each |
| urel_vld | input | 1 | Unified release valid |
| urel_idx | input | 5 | Unified release number, class decoded from its range |
| free_cnt | output | 16 | Free count per class, 4 bits each |
| nonempty | output | 4 | Non-zero free count per class |
| alloc_err | output | 1 | Sticky: allocate from an empty class |
| ovf_err | output | 1 | Sticky: release into a full class |

## Verification
Damage to a pool's head pointer appears on `alloc_idx` in the same cycle as the wrong number. Damage to the tail pointer or the storage stays hidden until the damaged entry reaches the head, which can take up to a full class depth of allocations. For that reason the bench drains pools completely after mixed releases. A wrong occupancy count shows one cycle later on `free_cnt` and `nonempty`. It then also appears as an error flag that is missing or spurious at the empty or full boundary. A decode error on the unified port appears as a count change in the wrong class, one cycle after the release.

// File: rtl/pfl_pkg.sv
package pfl_pkg;
  localparam int NUM_CLS = 4;

  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_FP  = 2'd1,
    CLS_CC  = 2'd2,
    CLS_VEC = 2'd3
  } reg_cls_e;
endpackage

// File: rtl/pfl_decode.sv
// Range decode of a physical number into its register class.
module pfl_decode
  import pfl_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int FP_BASE = 8,
  parameter int CC_BASE = 16,
  parameter int VEC_BASE = 20
) (
  input  logic [IDX_W-1:0] idx,
  output reg_cls_e         cls
);
  localparam logic [IDX_W:0] FP_B  = FP_BASE[IDX_W:0];
  localparam logic [IDX_W:0] CC_B  = CC_BASE[IDX_W:0];
  localparam logic [IDX_W:0] VEC_B = VEC_BASE[IDX_W:0];

  logic [IDX_W:0] idx_x;
  assign idx_x = {1'b0, idx};

  // Checked in priority order; anything past the cc range is vector.
  always_comb begin
    if (idx_x < FP_B)       cls = CLS_INT;
    else if (idx_x < CC_B)  cls = CLS_FP;
    else if (idx_x < VEC_B) cls = CLS_CC;
    else                    cls = CLS_VEC;
  end
endmodule

// File: rtl/pfl_pool.sv
// One class pool: circular buffer, one pop and up to two pushes per cycle.
module pfl_pool #(
  parameter int IDX_W = 5,
  parameter int CNT_W = 4,
  parameter int DEPTH = 8,
  parameter int RSV   = 2,
  parameter int BASE  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pop_req,
  input  logic             push_a,
  input  logic [IDX_W-1:0] idx_a,
  input  logic             push_b,
  input  logic [IDX_W-1:0] idx_b,
  output logic [IDX_W-1:0] head_idx,
  output logic [CNT_W-1:0] cnt,
  output logic             pop_bad,
  output logic             push_drop
);
  localparam int PW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FILL     = DEPTH - RSV;
  localparam int TAIL_RST = FILL % DEPTH;

  logic [IDX_W-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0] mem_d [DEPTH];
  logic [PW-1:0]    head_q, head_d, tail_q, tail_d, tail_b;
  logic [CNT_W-1:0] cnt_q, cnt_d, room;
  logic             pop_ok, acc_a, acc_b, mem_en;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    pop_ok  = pop_req && (cnt_q != '0);
    pop_bad = pop_req && (cnt_q == '0);
    // Free slots after this cycle's pop; a pop frees the head slot.
    room    = CNT_W'(DEPTH) - cnt_q + CNT_W'(pop_ok);
    acc_a   = push_a && (room != '0);
    acc_b   = push_b && (room > CNT_W'(acc_a));
    push_drop = (push_a && !acc_a) || (push_b && !acc_b);
    tail_b  = acc_a ? wrap_inc(tail_q) : tail_q;
    tail_d  = acc_b ? wrap_inc(tail_b) : tail_b;
    head_d  = pop_ok ? wrap_inc(head_q) : head_q;
    cnt_d   = cnt_q + CNT_W'(acc_a) + CNT_W'(acc_b) - CNT_W'(pop_ok);
    mem_en  = acc_a || acc_b;
    mem_d   = mem_q;
    if (acc_a) mem_d[tail_q] = idx_a;
    if (acc_b) mem_d[tail_b] = idx_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem_q[i] <= (i < FILL) ? IDX_W'(BASE + RSV + i) : '0;
      head_q <= '0;
      tail_q <= PW'(TAIL_RST);
      cnt_q  <= CNT_W'(FILL);
    end else begin
      if (mem_en) begin
        mem_q  <= mem_d;
        tail_q <= tail_d;
      end
      if (pop_ok) head_q <= head_d;
      if (mem_en || pop_ok) cnt_q <= cnt_d;
    end
  end

  assign head_idx = mem_q[head_q];
  assign cnt      = cnt_q;

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= DEPTH); // R4
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && cnt_q == '0 && !push_a && !push_b) |=> (cnt_q == '0)); // R5
  AST_SWAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && cnt_q != '0 && push_a && !push_b) |=> $stable(cnt_q)); // R6
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt_q) == DEPTH && !pop_req && (push_a || push_b)) |=> $stable(cnt_q)); // R7
  AST_DUAL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt_q) + 2 <= DEPTH && push_a && push_b && !pop_req)
      |=> (cnt_q == $past(cnt_q) + CNT_W'(2))); // R8
endmodule

// File: rtl/phys_free_list.sv
module phys_free_list
  import pfl_pkg::*;
#(
  parameter int INT_N = 8,
  parameter int INT_R = 2,
  parameter int FP_N  = 8,
  parameter int FP_R  = 2,
  parameter int CC_N  = 4,
  parameter int CC_R  = 1,
  parameter int VEC_N = 8,
  parameter int VEC_R = 2,
  localparam int TOTAL    = INT_N + FP_N + CC_N + VEC_N,
  localparam int IDX_W    = $clog2(TOTAL),
  localparam int MAX_AB   = (INT_N > FP_N) ? INT_N : FP_N,
  localparam int MAX_CD   = (CC_N > VEC_N) ? CC_N : VEC_N,
  localparam int MAX_N    = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD,
  localparam int CNT_W    = $clog2(MAX_N + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CLS-1:0]        alloc_req,
  output logic [NUM_CLS*IDX_W-1:0]  alloc_idx,
  input  logic [NUM_CLS-1:0]        rel_vld,
  input  logic [NUM_CLS*IDX_W-1:0]  rel_idx,
  input  logic                      urel_vld,
  input  logic [IDX_W-1:0]          urel_idx,
  output logic [NUM_CLS*CNT_W-1:0]  free_cnt,
  output logic [NUM_CLS-1:0]        nonempty,
  output logic                      alloc_err,
  output logic                      ovf_err
);
  localparam int FP_BASE  = INT_N;
  localparam int CC_BASE  = INT_N + FP_N;
  localparam int VEC_BASE = INT_N + FP_N + CC_N;

  reg_cls_e         ucls;
  logic [NUM_CLS-1:0] pop_bad, push_drop;
  logic             aerr_q, aerr_d, oerr_q, oerr_d;

  pfl_decode #(
    .IDX_W(IDX_W), .FP_BASE(FP_BASE), .CC_BASE(CC_BASE), .VEC_BASE(VEC_BASE)
  ) u_decode (
    .idx (urel_idx),
    .cls (ucls)
  );

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_cls
    localparam int DEP = (g == 0) ? INT_N : (g == 1) ? FP_N : (g == 2) ? CC_N : VEC_N;
    localparam int RSV = (g == 0) ? INT_R : (g == 1) ? FP_R : (g == 2) ? CC_R : VEC_R;
    localparam int BAS = (g == 0) ? 0 : (g == 1) ? FP_BASE : (g == 2) ? CC_BASE : VEC_BASE;
    logic push_u;
    assign push_u = urel_vld && (ucls == reg_cls_e'(g));

    pfl_pool #(
      .IDX_W(IDX_W), .CNT_W(CNT_W), .DEPTH(DEP), .RSV(RSV), .BASE(BAS)
    ) u_pool (
      .clk       (clk),
      .rst_n     (rst_n),
      .pop_req   (alloc_req[g]),
      .push_a    (rel_vld[g]),
      .idx_a     (rel_idx[g*IDX_W +: IDX_W]),
      .push_b    (push_u),
      .idx_b     (urel_idx),
      .head_idx  (alloc_idx[g*IDX_W +: IDX_W]),
      .cnt       (free_cnt[g*CNT_W +: CNT_W]),
      .pop_bad   (pop_bad[g]),
      .push_drop (push_drop[g])
    );

    assign nonempty[g] = (free_cnt[g*CNT_W +: CNT_W] != '0);
  end

  always_comb begin
    aerr_d = aerr_q | (|pop_bad);
    oerr_d = oerr_q | (|push_drop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aerr_q <= 1'b0;
      oerr_q <= 1'b0;
    end else begin
      if (|pop_bad)   aerr_q <= aerr_d;
      if (|push_drop) oerr_q <= oerr_d;
    end
  end

  assign alloc_err = aerr_q;
  assign ovf_err   = oerr_q;

  AST_ALLOC_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_err |=> alloc_err); // R5
  AST_OVF_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err); // R7
  AST_EMPTY_ALLOC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (|(alloc_req & ~nonempty)) |=> alloc_err); // R5
endmodule

// File: tb/phys_free_list_bench.sv
`timescale 1ns/1ps
module phys_free_list_bench;
  localparam int IW = 5;
  localparam int CW = 4;
  localparam int DEP  [4] = '{8, 8, 4, 8};
  localparam int BASE [4] = '{0, 8, 16, 20};
  localparam int RSV  [4] = '{2, 2, 1, 2};

  logic          clk = 1'b0;
  logic          rst_n;
  logic [3:0]    alloc_req;
  logic [19:0]   alloc_idx;
  logic [3:0]    rel_vld;
  logic [19:0]   rel_idx;
  logic          urel_vld;
  logic [4:0]    urel_idx;
  logic [15:0]   free_cnt;
  logic [3:0]    nonempty;
  logic          alloc_err, ovf_err;

  int n_chk = 0;
  int n_bad = 0;
  int mq [4][$];
  bit m_ae, m_oe;

  always #2.5 clk = ~clk;

  phys_free_list u_phys_free_list (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_idx(alloc_idx),
    .rel_vld(rel_vld), .rel_idx(rel_idx), .urel_vld(urel_vld), .urel_idx(urel_idx),
    .free_cnt(free_cnt), .nonempty(nonempty), .alloc_err(alloc_err), .ovf_err(ovf_err)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int cls_of(input int idx);
    if (idx < 8)  return 0;
    if (idx < 16) return 1;
    if (idx < 20) return 2;
    return 3;
  endfunction

  task automatic check_state(input string tag);
    for (int c = 0; c < 4; c++) begin
      chk(int'(free_cnt[c*CW +: CW]), mq[c].size(), {tag, " count"});
      chk(int'(nonempty[c]), int'(mq[c].size() != 0), {tag, " nonempty"});
    end
    chk(int'(alloc_err), int'(m_ae), {tag, " alloc_err"});
    chk(int'(ovf_err), int'(m_oe), {tag, " ovf_err"});
  endtask

  task automatic do_reset();
    rst_n = 1'b0; alloc_req = '0; rel_vld = '0; rel_idx = '0;
    urel_vld = 1'b0; urel_idx = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 4; c++) begin
      mq[c] = {};
      for (int i = RSV[c]; i < DEP[c]; i++) mq[c].push_back(BASE[c] + i);
    end
    m_ae = 1'b0; m_oe = 1'b0;
    #1;
  endtask

  // One cycle of stimulus; ri packs the direct release numbers, class 0 lowest.
  task automatic step(input logic [3:0] ar, input logic [3:0] rv, input logic [19:0] ri,
                      input bit uv, input int ui, input string tag);
    @(negedge clk);
    alloc_req = ar; rel_vld = rv; rel_idx = ri; urel_vld = uv; urel_idx = IW'(ui);
    #1;
    for (int c = 0; c < 4; c++)
      if (ar[c] && mq[c].size() > 0)
        chk(int'(alloc_idx[c*IW +: IW]), mq[c][0], {tag, " alloc_idx"});
    for (int c = 0; c < 4; c++) begin
      bit pop, pa, pb, aa, ab;
      int room;
      pop = ar[c] && (mq[c].size() > 0);
      if (ar[c] && mq[c].size() == 0) m_ae = 1'b1;
      room = DEP[c] - mq[c].size() + int'(pop);
      pa = rv[c];
      pb = uv && (cls_of(ui) == c);
      aa = pa && (room >= 1);
      ab = pb && (room >= 1 + int'(aa));
      if ((pa && !aa) || (pb && !ab)) m_oe = 1'b1;
      if (pop) void'(mq[c].pop_front());
      if (aa) mq[c].push_back(int'(ri[c*IW +: IW]));
      if (ab) mq[c].push_back(ui);
    end
    @(posedge clk);
    #1;
    alloc_req = '0; rel_vld = '0; urel_vld = 1'b0;
    check_state(tag);
  endtask

  task automatic t_reset_state();
    do_reset();
    check_state("R1 reset");
    chk(int'(free_cnt), {4'd6, 4'd3, 4'd6, 4'd6}, "R1 counts"); // R4
    chk(int'(alloc_idx), {5'd22, 5'd17, 5'd10, 5'd2}, "R10 heads at reset");
  endtask

  task automatic t_drain_int();
    do_reset();
    for (int i = 0; i < 6; i++) step(4'b0001, 4'b0000, '0, 1'b0, 0, "R1 drain int");
    chk(int'(nonempty[0]), 0, "R4 int empty");
    step(4'b0001, 4'b0000, '0, 1'b0, 0, "R5 alloc empty");
    chk(int'(alloc_err), 1, "R5 flag set");
    step(4'b0000, 4'b0000, '0, 1'b0, 0, "R5 sticky");
  endtask

  task automatic t_fifo_and_full();
    do_reset();
    step(4'b0000, 4'b0001, 20'd0, 1'b1, 1, "R8 dual release");
    chk(int'(free_cnt[3:0]), 8, "R8 int full");
    step(4'b0000, 4'b0001, 20'd5, 1'b0, 0, "R7 release into full");
    chk(int'(ovf_err), 1, "R7 overflow");
    for (int i = 0; i < 8; i++) step(4'b0001, 4'b0000, '0, 1'b0, 0, "R2 drain order");
  endtask

  task automatic t_decode();
    do_reset();
    step(4'b0000, 4'b0000, '0, 1'b1, 7,  "R3 int upper edge");
    step(4'b0000, 4'b0000, '0, 1'b1, 8,  "R3 fp lower edge");
    step(4'b0000, 4'b0000, '0, 1'b1, 16, "R3 cc lower edge");
    step(4'b0000, 4'b0000, '0, 1'b1, 20, "R3 vec lower edge");
    step(4'b0000, 4'b0000, '0, 1'b1, 30, "R3 beyond range");
    step(4'b0000, 4'b0000, '0, 1'b1, 19, "R3 cc full drop");
    for (int i = 0; i < 8; i++) step(4'b1000, 4'b0000, '0, 1'b0, 0, "R2 vec order");
  endtask

  task automatic t_same_cycle();
    do_reset();
    step(4'b0100, 4'b0100, {5'd0, 5'd16, 5'd0, 5'd0}, 1'b0, 0, "R6 swap cc");
    step(4'b0000, 4'b0100, {5'd0, 5'd18, 5'd0, 5'd0}, 1'b0, 0, "R6 fill cc");
    step(4'b0100, 4'b0100, {5'd0, 5'd19, 5'd0, 5'd0}, 1'b0, 0, "R6 swap when full");
    step(4'b0001, 4'b0000, '0, 1'b0, 0, "R9 int only");
    step(4'b1111, 4'b0000, '0, 1'b0, 0, "R10 all classes");
    step(4'b0010, 4'b0000, '0, 1'b1, 9, "R9 fp alloc with release");
    for (int i = 0; i < 4; i++) step(4'b0100, 4'b0000, '0, 1'b0, 0, "R2 cc order");
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    t_reset_state();
    t_drain_int();
    t_fifo_and_full();
    t_decode();
    t_same_cycle();
    finish_up();
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end
endmodule